// File: doc/BRIEF.md
# Scrypt Scratchpad Sequencer with Lookup Gap

This block runs the memory-hard middle loop of scrypt. The parameters are a cost of N = 1024 and a block factor of 1, on a 1024-bit working state that is split into a lower half and an upper half. The block does not compute the mixing function itself. It hands each step to an external BlockMix unit over a launch/finish handshake and captures the result. It also steps the two phases of the loop. The first phase, fill, produces N successive states. The second phase, mix, performs N data-dependent lookups into those states.

To save on-chip RAM, the scratchpad keeps only every GAP-th fill state, where GAP is a compile-time power of two (1, 2 or 4). The RAM then holds N/GAP entries of 1024 bits, so a gap of 4 needs a quarter of the full 1 Mbit. During the mix phase, a lookup may hit a state that was not kept. In that case the block reads the nearest kept state below it and replays the missing BlockMix steps on a private copy. The final result is identical to the full-scratchpad algorithm. The cost is extra BlockMix runs: with a gap of 4, about 3.5·N runs per hash instead of 2·N.

Top module: `lg_romix_seq`

## Requirements
- R1: Out of reset, `busy`, `done` and `bm_start` are low, and no BlockMix launch happens while the block is idle.
- R2: A `start` seen at a clock edge while idle raises `busy` from the next cycle. The first launch follows in that same cycle, with `bm_in` equal to `in_state`.
- R3: The fill phase makes exactly N launches, one per step. Launch i carries the state after i BlockMix runs on `in_state`.
- R4: `bm_start` is a one-cycle pulse. No new launch is issued until `bm_done` for the previous launch has been seen.
- R5: Only fill states whose step index is a multiple of GAP are written to the scratchpad, at slot index/GAP. The scratchpad never reads and writes in the same cycle.
- R6: Each mix lookup index j is the low log2(N) bits of word 0 of the upper half, that is bits [HALF_W+log2(N)-1 : HALF_W] of the working state (HALF_W = STATE_W/2).
- R7: For a lookup with r = j mod GAP > 0, the block reads slot (j−r)/GAP. It then launches r rebuild steps whose inputs are the fill states j−r, j−r+1, …, j−1, in that order. When r = 0, no rebuild launch occurs.
- R8: Each mix iteration ends with one launch whose input is the working state XOR the fill state j. The result of that launch becomes the new working state. The block performs N such iterations.
- R9: One hash costs exactly 2·N + Σ(j mod GAP) launches, with the sum taken over the N lookups.
- R10: After the last mix step, `done` is high for exactly one cycle and `busy` falls in the following cycle. `out_state` holds the final working state and keeps it while idle.
- R11: A `start` while `busy` is high is ignored. The running hash completes with its original input.
- R12: `out_state` equals the result of the full-scratchpad algorithm for the same `in_state`, whatever the value of GAP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin a hash with `in_state` (ignored while busy) |
| in_state | input | STATE_W | Initial 1024-bit working state |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle pulse when the result is ready |
| out_state | output | STATE_W | Final working state |
| bm_start | output | 1 | One-cycle launch of the external BlockMix |
| bm_in | output | STATE_W | BlockMix input, valid with `bm_start` |
| bm_done | input | 1 | BlockMix finished, `bm_out` valid |
| bm_out | input | STATE_W | BlockMix result |

## Verification
An accepted start raises `busy` one edge later, and the first launch appears in that same cycle. `bm_out` is captured at the edge where `bm_done` is high, and the next launch follows in the cycle after that edge. `done` appears in the cycle after the last mix result is captured, and `busy` drops one cycle after `done`. The bench samples every output on the falling edge. Its BlockMix model answers one cycle after each launch and records every launch input into an order-sensitive signature and a count. Those are compared with a full-scratchpad model computed in the bench. The result and the fall of `busy` are checked on the falling edges where `done` is high and the one after.

// File: rtl/lg_romix_pkg.sv
package lg_romix_pkg;

  // Sequencer states: fill loop, lookup, rebuild loop, mix step, finish
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL_GO,
    ST_FILL_WAIT,
    ST_MIX_RD,
    ST_MIX_LD,
    ST_REB_GO,
    ST_REB_WAIT,
    ST_MIX_GO,
    ST_MIX_WAIT,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/lg_index_split.sv
// Splits a scratchpad index into the stored slot and the distance past it.
module lg_index_split #(
  parameter int N   = 1024,
  parameter int GAP = 4,
  localparam int IW = $clog2(N),
  localparam int GB = $clog2(GAP),
  localparam int BW = IW - GB,
  localparam int RW = (GB > 0) ? GB : 1
) (
  input  logic [IW-1:0] idx,
  output logic [BW-1:0] slot,
  output logic [RW-1:0] rem
);

  generate
    if (GB == 0) begin : g_full
      assign slot = idx;
      assign rem  = '0;
    end else begin : g_gap
      assign slot = idx[IW-1:GB];
      assign rem  = idx[GB-1:0];
    end
  endgenerate

endmodule

// File: rtl/lg_scratch_ram.sv
// Single-port-style scratchpad: synchronous write, registered read.
module lg_scratch_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/lg_romix_seq.sv
// Memory-hard loop sequencer with a decimated scratchpad and on-demand rebuild.
module lg_romix_seq
  import lg_romix_pkg::*;
#(
  parameter int N       = 1024,
  parameter int GAP     = 4,
  parameter int STATE_W = 1024,
  localparam int HALF_W = STATE_W / 2,
  localparam int IW     = $clog2(N),
  localparam int GB     = $clog2(GAP),
  localparam int DEPTH  = N / GAP,
  localparam int BW     = IW - GB,
  localparam int RW     = (GB > 0) ? GB : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [STATE_W-1:0] in_state,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] out_state,
  output logic               bm_start,
  output logic [STATE_W-1:0] bm_in,
  input  logic               bm_done,
  input  logic [STATE_W-1:0] bm_out
);

  seq_state_e state_q, state_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [RW-1:0]      rem_q, rem_d;
  logic [STATE_W-1:0] x_q, x_d;
  logic [STATE_W-1:0] tmp_q, tmp_d;
  logic               x_en, tmp_en;
  logic               ram_we, ram_re;
  logic [STATE_W-1:0] ram_rd;
  logic [BW-1:0]      fill_slot, mix_slot;
  logic [RW-1:0]      fill_rem, mix_rem;
  logic [IW-1:0]      lookup_j;

  // Lookup index: low bits of word 0 of the upper half
  assign lookup_j = x_q[HALF_W +: IW];

  lg_index_split #(.N(N), .GAP(GAP)) u_fill_split (
    .idx  (idx_q),
    .slot (fill_slot),
    .rem  (fill_rem)
  );

  lg_index_split #(.N(N), .GAP(GAP)) u_mix_split (
    .idx  (lookup_j),
    .slot (mix_slot),
    .rem  (mix_rem)
  );

  lg_scratch_ram #(.DEPTH(DEPTH), .WIDTH(STATE_W)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (fill_slot),
    .wr_data (x_q),
    .rd_en   (ram_re),
    .rd_addr (mix_slot),
    .rd_data (ram_rd)
  );

  // Next-state and output decode
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rem_d    = rem_q;
    x_d      = x_q;
    x_en     = 1'b0;
    tmp_d    = tmp_q;
    tmp_en   = 1'b0;
    bm_start = 1'b0;
    bm_in    = x_q;
    ram_we   = 1'b0;
    ram_re   = 1'b0;
    done     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          x_d     = in_state;
          x_en    = 1'b1;
          idx_d   = '0;
          state_d = ST_FILL_GO;
        end
      end
      ST_FILL_GO: begin
        bm_start = 1'b1;
        bm_in    = x_q;
        ram_we   = (fill_rem == '0);
        state_d  = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (bm_done) begin
          x_d  = bm_out;
          x_en = 1'b1;
          if (idx_q == IW'(N - 1)) begin
            idx_d   = '0;
            state_d = ST_MIX_RD;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_FILL_GO;
          end
        end
      end
      ST_MIX_RD: begin
        ram_re  = 1'b1;
        rem_d   = mix_rem;
        state_d = ST_MIX_LD;
      end
      ST_MIX_LD: begin
        tmp_d   = ram_rd;
        tmp_en  = 1'b1;
        state_d = (rem_q == '0) ? ST_MIX_GO : ST_REB_GO;
      end
      ST_REB_GO: begin
        bm_start = 1'b1;
        bm_in    = tmp_q;
        state_d  = ST_REB_WAIT;
      end
      ST_REB_WAIT: begin
        if (bm_done) begin
          tmp_d   = bm_out;
          tmp_en  = 1'b1;
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == RW'(1)) ? ST_MIX_GO : ST_REB_GO;
        end
      end
      ST_MIX_GO: begin
        bm_start = 1'b1;
        bm_in    = x_q ^ tmp_q;
        state_d  = ST_MIX_WAIT;
      end
      ST_MIX_WAIT: begin
        if (bm_done) begin
          x_d  = bm_out;
          x_en = 1'b1;
          if (idx_q == IW'(N - 1)) begin
            state_d = ST_FIN;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_MIX_RD;
          end
        end
      end
      ST_FIN: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
    end
  end

  // Datapath registers, enabled only when loaded
  always_ff @(posedge clk) begin
    if (x_en) begin
      x_q <= x_d;
    end
    if (tmp_en) begin
      tmp_q <= tmp_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign out_state = x_q;

  // R2: an accepted start makes the block busy on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R4: a launch is a single-cycle pulse
  assert_launch_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bm_start |=> !bm_start);

  // R5: scratchpad never reads and writes in one cycle
  assert_ram_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  // R7: a rebuild launch only happens with steps still outstanding
  assert_rebuild_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_start && state_q == ST_REB_GO) |-> (rem_q != '0));

  // R10: done lasts one cycle and busy drops right after
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R1: no launch while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bm_start);

endmodule

// File: tb/tb_lg_romix_seq.sv
module tb_lg_romix_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 1024;
  localparam int GAP        = 4;
  localparam int SW         = 1024;
  localparam int HALF       = SW / 2;
  localparam int IW         = $clog2(N);
  localparam int NWORD      = SW / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] in_state = '0;
  logic          busy, done, bm_start;
  logic [SW-1:0] out_state, bm_in;
  logic          bm_done = 1'b0;
  logic [SW-1:0] bm_out = '0;

  int checks = 0;
  int fails  = 0;

  // observation from the BlockMix model
  int            n_launch = 0;
  int            overlap  = 0;
  logic [63:0]   obs_sig  = '0;
  logic [SW-1:0] first_in = '0;
  logic [SW-1:0] cap      = '0;
  bit            pend     = 1'b0;

  logic [SW-1:0] vref [N];

  lg_romix_seq #(.N(N), .GAP(GAP), .STATE_W(SW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_state  (in_state),
    .busy      (busy),
    .done      (done),
    .out_state (out_state),
    .bm_start  (bm_start),
    .bm_in     (bm_in),
    .bm_done   (bm_done),
    .bm_out    (bm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Stand-in mixing function used by both the model and the reference
  function automatic logic [SW-1:0] mixf(input logic [SW-1:0] x);
    logic [SW-1:0] y;
    for (int k = 0; k < NWORD; k++) begin
      logic [31:0] w, n, p;
      w = x[k*32 +: 32];
      n = x[((k + 1) % NWORD)*32 +: 32];
      p = x[((k + NWORD - 1) % NWORD)*32 +: 32];
      y[k*32 +: 32] = (w ^ {n[24:0], n[31:25]}) + p + (32'(k) + 32'd1) * 32'h9E37_79B9;
    end
    return y;
  endfunction

  // Order-sensitive signature of launch inputs
  function automatic logic [63:0] sig_step(input logic [63:0] s, input logic [SW-1:0] x);
    logic [63:0] f;
    f = '0;
    for (int k = 0; k < SW / 64; k++) begin
      logic [63:0] v;
      v = x[k*64 +: 64];
      f = f ^ ((v << k) | (v >> (64 - k)));
    end
    return {s[62:0], s[63]} ^ f;
  endfunction

  // Full-scratchpad reference with the expected launch trace
  task automatic ref_run(input logic [SW-1:0] b, output logic [SW-1:0] res,
                         output int cnt, output logic [63:0] sig);
    logic [SW-1:0] x;
    x = b; cnt = 0; sig = '0;
    for (int i = 0; i < N; i++) begin
      vref[i] = x;
      sig = sig_step(sig, x);
      cnt++;
      x = mixf(x);
    end
    for (int it = 0; it < N; it++) begin
      int j, r;
      j = int'(x[HALF +: IW]);
      r = j % GAP;
      for (int k = 0; k < r; k++) begin
        sig = sig_step(sig, vref[j - r + k]);
        cnt++;
      end
      sig = sig_step(sig, x ^ vref[j]);
      cnt++;
      x = mixf(x ^ vref[j]);
    end
    res = x;
  endtask

  // BlockMix model: answers one cycle after each launch
  always @(negedge clk) begin
    if (!rst_n) begin
      bm_done <= 1'b0;
      pend = 1'b0;
    end else begin
      bm_done <= pend;
      if (pend) bm_out <= mixf(cap);
      if (bm_start) begin
        if (pend) overlap++;
        cap = bm_in;
        pend = 1'b1;
        if (n_launch == 0) first_in = bm_in;
        n_launch++;
        obs_sig = sig_step(obs_sig, bm_in);
      end else begin
        pend = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", $sformatf("busy in reset actual=%0b expected=0", busy));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1",
        $sformatf("idle flags actual=%0b%0b expected=00", busy, done));
    chk(bm_start == 1'b0 && n_launch == 0, "R1",
        $sformatf("idle launches actual=%0d expected=0", n_launch));
  endtask

  task automatic run_hash(input logic [SW-1:0] b, input bit poke,
                          input logic [SW-1:0] b2, input string name);
    logic [SW-1:0] exp_res, got;
    int            exp_cnt, cyc;
    logic [63:0]   exp_sig;
    ref_run(b, exp_res, exp_cnt, exp_sig);
    while (busy) @(negedge clk);
    n_launch = 0; obs_sig = '0; overlap = 0;
    start = 1'b1; in_state = b;
    @(negedge clk);
    start = 1'b0; in_state = ~b;
    chk(busy == 1'b1, "R2", $sformatf("%s busy after start actual=%0b expected=1", name, busy));
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1; in_state = b2;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      chk(1'b0, "R10", $sformatf("%s done actual=never expected=pulse", name));
      return;
    end
    got = out_state;
    chk(got == exp_res, poke ? "R11" : "R12",
        $sformatf("%s result actual=%h expected=%h", name, got, exp_res));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10",
        $sformatf("%s after done actual=%0b%0b expected=00", name, done, busy));
    repeat (5) @(negedge clk);
    chk(out_state == got, "R10", $sformatf("%s held result actual=%h expected=%h", name, out_state, got));
    chk(first_in == b, "R2", $sformatf("%s first launch actual=%h expected=%h", name, first_in, b));
    chk(n_launch == exp_cnt, "R9",
        $sformatf("%s launches actual=%0d expected=%0d", name, n_launch, exp_cnt));
    chk(obs_sig == exp_sig, "R3 R5 R6 R7 R8",
        $sformatf("%s launch trace actual=%h expected=%h", name, obs_sig, exp_sig));
    chk(overlap == 0, "R4", $sformatf("%s overlapped launches actual=%0d expected=0", name, overlap));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [SW-1:0] pat;
    for (int k = 0; k < NWORD; k++) pat[k*32 +: 32] = 32'h0123_4567 * (32'(k) + 32'd3);
    t_reset();
    run_hash('0, 1'b0, '0, "zero");
    run_hash({NWORD{32'hA5C3_0F96}}, 1'b0, '0, "rep");
    run_hash(pat, 1'b0, '0, "ramp");
    run_hash(~pat, 1'b1, pat, "poke");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule